// File: doc/BRIEF.md
# Host-to-Processor Word Transfer Channel

This block carries data one way, from an 8-bit host bus into a 24-bit receive word on the processor side. The host loads a staging buffer of three byte lanes: high, middle and low. The low lane commits the word. It can load all three lanes, only the middle and low lanes, or only the low lane. Lanes the host skips keep whatever they held before, so a short load reuses the upper bytes of the previous word.

Two flags coordinate the transfer. A host-visible "staging empty" flag shows that the buffer may be written. A processor-visible "receive full" flag shows that a word is waiting. When both flags are clear, the committed word moves into the receive register on the next clock edge. When the processor reads the receive register, the full flag clears and the empty flag sets again.

Each side has an enable bit and a level request output. The host request follows "staging empty". The processor request follows "receive full" and carries the fixed vector address 0x0030. Both sides use a simple synchronous register access port that decodes addresses.

Top module: `hostlink_top`

## Requirements
- R1: After reset, staging-empty is 1, receive-full is 0, both enable bits are 0, every byte lane and the receive word are 0, and `h_req`, `p_irq` and `p_vec` are 0.
- R2: Host address 0 reads back bit 1 = staging-empty and bit 0 = host request enable. Writing host address 0 loads bit 0 of `h_wdata` into the enable. `h_req` is 1 exactly when the enable and staging-empty are both 1.
- R3: While staging-empty is 1, a host write to address 1, 2 or 3 loads word bits 23:16, 15:8 or 7:0 respectively. Host reads of those addresses return the lane. Lanes not written keep their earlier value, so a load of three, two or one bytes forms the word.
- R4: A host write to address 3 (the low lane) accepted while staging-empty is 1 clears staging-empty at that clock edge.
- R5: On the clock edge after staging-empty and receive-full are both seen at 0, the staged word is copied into the receive register and receive-full is set.
- R6: A processor read of address 1 while receive-full is 1 returns the receive word and, at that edge, clears receive-full and sets staging-empty. A read while receive-full is 0 changes neither flag. The two flags are never both 1.
- R7: Processor address 0 reads back bit 1 = receive-full and bit 0 = receive interrupt enable. A write to address 0 loads the enable. `p_irq` is a level that is 1 while the enable and receive-full are both 1. `p_vec` shows 0x0030 while `p_irq` is 1 and 0 otherwise.
- R8: Host writes to addresses 1 to 3 while staging-empty is 0 are ignored. They leave every lane and staging-empty unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 2 | Host register address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data for `h_addr` |
| h_req | output | 1 | Host request: buffer may be loaded |
| p_we | input | 1 | Processor write strobe (control register) |
| p_re | input | 1 | Processor read strobe |
| p_addr | input | 1 | Processor register address |
| p_wdata | input | 1 | Value written to the receive interrupt enable |
| p_rdata | output | 24 | Processor read data for `p_addr` |
| p_irq | output | 1 | Processor interrupt request, level |
| p_vec | output | 16 | Vector address while `p_irq` is 1 |

## Verification
A low-lane write registered at edge n clears staging-empty right after edge n. Receive-full, `p_irq` and `p_vec` follow one edge later, at n+1. A processor read registered at edge m returns its data combinationally in that same cycle, and both flags flip right after edge m. Enable writes show on the request outputs right after the edge that registers them. The bench drives on falling edges and samples read data 1 ns after driving. For each result it samples in the low phase that follows the edge counted above. The check right after a commit also confirms that receive-full is still 0 there, which proves the single cycle of latency.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
  localparam int BYTE_W_DEF = 8;
  localparam int NBYTES_DEF = 3;
  localparam int VEC_W_DEF  = 16;

  // LSB position inside the word of the lane at host address addr (1 = most significant).
  function automatic int lane_lsb(input int addr, input int nbytes, input int bw);
    return (nbytes - addr) * bw;
  endfunction

  // Host address that commits the word (the least significant lane).
  function automatic int commit_addr(input int nbytes);
    return nbytes;
  endfunction
endpackage

// File: rtl/hostlink_txbuf.sv
module hostlink_txbuf
  import hostlink_pkg::*;
#(
  parameter int BYTE_W  = BYTE_W_DEF,
  parameter int NBYTES  = NBYTES_DEF,
  localparam int WORD_W  = BYTE_W * NBYTES,
  localparam int HADDR_W = $clog2(NBYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_we,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic [BYTE_W-1:0]  h_wdata,
  input  logic               rd_take,
  output logic [WORD_W-1:0]  buf_word,
  output logic               tx_empty,
  output logic               req_en,
  output logic               commit_evt,
  output logic [BYTE_W-1:0]  h_rdata
);
  logic [BYTE_W-1:0] lane_q [NBYTES];
  logic              lane_wr;

  assign lane_wr    = h_we && tx_empty && (h_addr != '0);
  assign commit_evt = lane_wr && (h_addr == HADDR_W'(commit_addr(NBYTES)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NBYTES; k++) lane_q[k] <= '0;
    end else if (lane_wr) begin
      for (int k = 0; k < NBYTES; k++)
        if (h_addr == HADDR_W'(k + 1)) lane_q[k] <= h_wdata;
    end
  end

  generate
    for (genvar g = 0; g < NBYTES; g++) begin : g_pack
      assign buf_word[lane_lsb(g + 1, NBYTES, BYTE_W) +: BYTE_W] = lane_q[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tx_empty <= 1'b1;
    else if (commit_evt) tx_empty <= 1'b0;
    else if (rd_take)    tx_empty <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        req_en <= 1'b0;
    else if (h_we && h_addr == '0)     req_en <= h_wdata[0];
  end

  always_comb begin
    h_rdata = '0;
    if (h_addr == '0) begin
      h_rdata[1] = tx_empty;
      h_rdata[0] = req_en;
    end else begin
      for (int k = 0; k < NBYTES; k++)
        if (h_addr == HADDR_W'(k + 1)) h_rdata = lane_q[k];
    end
  end
endmodule

// File: rtl/hostlink_rxreg.sv
module hostlink_rxreg
  import hostlink_pkg::*;
#(
  parameter int WORD_W = BYTE_W_DEF * NBYTES_DEF,
  parameter int VEC_W  = VEC_W_DEF,
  parameter logic [VEC_W-1:0] VEC = VEC_W'(16'h0030)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p_we,
  input  logic              p_re,
  input  logic              p_addr,
  input  logic              p_wdata,
  input  logic              xfer_evt,
  input  logic [WORD_W-1:0] buf_word,
  output logic              rx_full,
  output logic [WORD_W-1:0] rx_word,
  output logic              pread_evt,
  output logic [WORD_W-1:0] p_rdata,
  output logic              p_irq,
  output logic [VEC_W-1:0]  p_vec
);
  logic irq_en;

  assign pread_evt = p_re && p_addr && rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rx_full <= 1'b0;
    else if (xfer_evt)  rx_full <= 1'b1;
    else if (pread_evt) rx_full <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_word <= '0;
    else if (xfer_evt) rx_word <= buf_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               irq_en <= 1'b0;
    else if (p_we && !p_addr) irq_en <= p_wdata;
  end

  always_comb begin
    p_rdata = '0;
    if (p_addr) p_rdata = rx_word;
    else begin
      p_rdata[1] = rx_full;
      p_rdata[0] = irq_en;
    end
  end

  assign p_irq = irq_en && rx_full;
  assign p_vec = p_irq ? VEC : '0;
endmodule

// File: rtl/hostlink_top.sv
module hostlink_top
  import hostlink_pkg::*;
#(
  parameter int BYTE_W = BYTE_W_DEF,
  parameter int NBYTES = NBYTES_DEF,
  parameter int VEC_W  = VEC_W_DEF,
  parameter logic [VEC_W-1:0] VEC = VEC_W'(16'h0030),
  localparam int WORD_W  = BYTE_W * NBYTES,
  localparam int HADDR_W = $clog2(NBYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_we,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic [BYTE_W-1:0]  h_wdata,
  output logic [BYTE_W-1:0]  h_rdata,
  output logic               h_req,
  input  logic               p_we,
  input  logic               p_re,
  input  logic               p_addr,
  input  logic               p_wdata,
  output logic [WORD_W-1:0]  p_rdata,
  output logic               p_irq,
  output logic [VEC_W-1:0]   p_vec
);
  logic [WORD_W-1:0] buf_word;
  logic [WORD_W-1:0] rx_word;
  logic tx_empty, rx_full, req_en;
  logic commit_evt, xfer_evt, pread_evt;

  assign xfer_evt = !tx_empty && !rx_full;
  assign h_req    = req_en && tx_empty;

  hostlink_txbuf #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_txbuf (
    .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .rd_take(pread_evt), .buf_word(buf_word), .tx_empty(tx_empty),
    .req_en(req_en), .commit_evt(commit_evt), .h_rdata(h_rdata)
  );

  hostlink_rxreg #(.WORD_W(WORD_W), .VEC_W(VEC_W), .VEC(VEC)) u_rxreg (
    .clk(clk), .rst_n(rst_n), .p_we(p_we), .p_re(p_re), .p_addr(p_addr),
    .p_wdata(p_wdata), .xfer_evt(xfer_evt), .buf_word(buf_word),
    .rx_full(rx_full), .rx_word(rx_word), .pread_evt(pread_evt),
    .p_rdata(p_rdata), .p_irq(p_irq), .p_vec(p_vec)
  );
endmodule

// File: rtl/hostlink_chk.sv
module hostlink_chk #(
  parameter int WORD_W  = 24,
  parameter int HADDR_W = 2,
  parameter int VEC_W   = 16,
  parameter logic [VEC_W-1:0] VEC = VEC_W'(16'h0030)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               h_we,
  input logic [HADDR_W-1:0] h_addr,
  input logic               h_req,
  input logic               tx_empty,
  input logic               rx_full,
  input logic               commit_evt,
  input logic               xfer_evt,
  input logic               pread_evt,
  input logic [WORD_W-1:0]  buf_word,
  input logic [WORD_W-1:0]  rx_word,
  input logic               p_irq,
  input logic [VEC_W-1:0]   p_vec
);
  AST_REQ_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    h_req |-> tx_empty); // R2
  AST_COMMIT_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> !tx_empty && !rx_full); // R4
  AST_XFER_LOADS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_evt |=> rx_full && rx_word == $past(buf_word)); // R5
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    pread_evt |=> !rx_full && tx_empty); // R6
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_empty && rx_full)); // R6
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    p_irq |-> rx_full && p_vec == VEC); // R7
  AST_LOCKED_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && !tx_empty && h_addr != '0) |=> $stable(buf_word)); // R8
endmodule

bind hostlink_top hostlink_chk #(
  .WORD_W(WORD_W), .HADDR_W(HADDR_W), .VEC_W(VEC_W), .VEC(VEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_addr(h_addr), .h_req(h_req),
  .tx_empty(tx_empty), .rx_full(rx_full), .commit_evt(commit_evt),
  .xfer_evt(xfer_evt), .pread_evt(pread_evt), .buf_word(buf_word),
  .rx_word(rx_word), .p_irq(p_irq), .p_vec(p_vec)
);

// File: tb/test_hostlink_top.sv
`timescale 1ns/1ps
module test_hostlink_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_we = 1'b0;
  logic [1:0] h_addr = '0;
  logic [7:0] h_wdata = '0;
  logic [7:0] h_rdata;
  logic h_req;
  logic p_we = 1'b0, p_re = 1'b0, p_addr = 1'b0, p_wdata = 1'b0;
  logic [23:0] p_rdata;
  logic p_irq;
  logic [15:0] p_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hostlink_top i_hostlink_top (
    .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_req(h_req), .p_we(p_we), .p_re(p_re), .p_addr(p_addr),
    .p_wdata(p_wdata), .p_rdata(p_rdata), .p_irq(p_irq), .p_vec(p_vec)
  );

  // {write high lane, write middle lane, high, middle, low, expected word}
  localparam logic [49:0] STIM [5] = '{
    {2'b11, 24'h123456, 24'h123456},
    {2'b01, 24'h00ABCD, 24'h12ABCD},
    {2'b00, 24'h0000EF, 24'h12ABEF},
    {2'b11, 24'hFF007F, 24'hFF007F},
    {2'b00, 24'h000001, 24'hFF0001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); h_we = 1'b1; h_addr = a; h_wdata = d;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [7:0] v);
    h_addr = a; #1 v = h_rdata;
  endtask

  task automatic pwrite(input logic v);
    @(negedge clk); p_we = 1'b1; p_addr = 1'b0; p_wdata = v;
    @(negedge clk); p_we = 1'b0;
  endtask

  task automatic pstat(output logic [1:0] v);
    p_addr = 1'b0; #1 v = p_rdata[1:0];
  endtask

  task automatic pread(output logic [23:0] v);
    @(negedge clk); p_re = 1'b1; p_addr = 1'b1; #1 v = p_rdata;
    @(negedge clk); p_re = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] hb;
    logic [1:0] ps;
    logic [23:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    hread(2'd0, hb); check("R1 host status", hb, 8'h02);
    for (int a = 1; a < 4; a++) begin
      hread(2'(a), hb); check("R1 lane", hb, 8'h00);
    end
    pstat(ps); check("R1 proc status", ps, 2'b00);
    p_addr = 1'b1; #1 check("R1 rx word", p_rdata, 24'h0);
    check("R1 h_req", h_req, 1'b0);
    check("R1 p_irq", p_irq, 1'b0);
    check("R1 p_vec", p_vec, 16'h0);

    // R4: one-byte commit, enables off
    hwrite(2'd3, 8'h5A);
    hread(2'd0, hb); check("R4 empty cleared", hb, 8'h00);
    pstat(ps); check("R5 full not yet set", ps, 2'b00);
    @(negedge clk);
    pstat(ps); check("R5 full set after one edge", ps, 2'b10);
    check("R7 irq off while enable 0", p_irq, 1'b0);
    check("R2 h_req off while enable 0", h_req, 1'b0);

    // R8: lane writes while staging not empty are ignored
    hwrite(2'd1, 8'hC3);
    hread(2'd1, hb); check("R8 high lane kept", hb, 8'h00);
    hwrite(2'd3, 8'h77);
    hread(2'd3, hb); check("R8 low lane kept", hb, 8'h5A);
    hread(2'd0, hb); check("R8 empty stays 0", hb, 8'h00);

    // R7: level request follows the enable
    pwrite(1'b1);
    check("R7 irq raised", p_irq, 1'b1);
    check("R7 vector", p_vec, 16'h0030);
    @(negedge clk);
    check("R7 irq held", p_irq, 1'b1);
    pwrite(1'b0);
    check("R7 irq dropped by enable", p_irq, 1'b0);
    check("R7 vector cleared", p_vec, 16'h0000);

    // R6: read releases both sides
    pread(w); check("R6 read word", w, 24'h00005A);
    pstat(ps); check("R6 full cleared", ps, 2'b00);
    hread(2'd0, hb); check("R6 empty set", hb, 8'h02);
    pread(w);
    pstat(ps); check("R6 read while empty leaves flags", ps, 2'b00);
    hread(2'd0, hb); check("R6 empty unchanged", hb, 8'h02);

    // R2: host request enable
    hwrite(2'd0, 8'h01);
    check("R2 h_req raised", h_req, 1'b1);
    hread(2'd0, hb); check("R2 status readback", hb, 8'h03);
    pwrite(1'b1);

    // Table: one-, two- and three-byte loads (R3, R5, R6, R7)
    for (int i = 0; i < 5; i++) begin
      logic [49:0] e;
      e = STIM[i];
      check("R2 h_req while empty", h_req, 1'b1);
      if (e[49]) hwrite(2'd1, e[47:40]);
      if (e[48]) hwrite(2'd2, e[39:32]);
      hwrite(2'd3, e[31:24]);
      check("R2 h_req after commit", h_req, 1'b0);
      hread(2'd0, hb); check("R4 empty cleared", hb, 8'h01);
      @(negedge clk);
      pstat(ps); check("R5 full", ps, 2'b11);
      check("R7 irq", p_irq, 1'b1);
      check("R7 vector", p_vec, 16'h0030);
      pread(w); check("R3 assembled word", w, e[23:0]);
      pstat(ps); check("R6 full cleared", ps, 2'b01);
      check("R7 irq cleared", p_irq, 1'b0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule